// File: doc/BRIEF.md
# Processor status push sequencer

This block carries out the privileged "push status" step of a processor. When it gets a start pulse it stores the current execution environment on a memory stack. That environment is the sixteen general registers and the two old status words. The frame is fixed at 28 words. It writes one word per clock, always to consecutive ascending addresses above the initial stack top. Slots that carry no environment data are written with zero. While it writes, it steps the stack pointer fields on every access: the top address goes up, the word count goes up and the space count goes down. Overflow and exhaustion never abort the sequence.

After the last access the block forms the new status doubleword. Most of it comes from a fetched doubleword. The three interrupt-group inhibit bits are the OR of the fetched and old bits. The register block pointer comes from the fetched doubleword only when the LP flag is set; otherwise the old one is kept. Status doubleword bits are numbered with bit 0 as the most significant bit. Inhibit bits 37..39 are therefore vector bits [26:24], and register block pointer bits 56..59 are vector bits [7:4].

The controller has three states. ST_IDLE waits for start. ST_PUSH emits one write per cycle for 28 cycles. ST_FINISH raises done for one cycle. The transitions are: start in ST_IDLE goes to ST_PUSH; the 28th write goes from ST_PUSH to ST_FINISH; ST_FINISH always goes back to ST_IDLE.

Top module: `status_push_seq`

## Requirements
- R1: After reset, busy, done and mem_we are 0, new_psw is 0, and the pointer outputs are 0.
- R2: A start pulse in idle is followed, from the next cycle, by exactly 28 writes on consecutive cycles, to addresses initial top +1 through +28 in ascending order.
- R3: General register n (n = 0..15, taken from gpr_flat[32n+31:32n]) is written to initial top + n + 1.
- R4: Old status bits [63:32] are written to initial top + 25 and bits [31:0] to initial top + 26.
- R5: Slots +17..+24, +27 and +28 are written with zero.
- R6: When done is high, ptr_top equals initial top + 28 and ptr_wc equals initial word count + 28, both modulo their field widths. ptr_sc equals initial space count − 28, modulo 2^15, even when that wraps below zero.
- R7: If the word count passes 32767 during the sequence, ptr_ovf becomes 1 and the count wraps; a flag already set stays set; the sequence still completes all 28 writes.
- R8: Except for bits [26:24] and [7:4], new_psw equals the fetched doubleword.
- R9: new_psw[7:4] comes from the fetched doubleword when lp_flag is 1, and from the old status doubleword when it is 0.
- R10: new_psw[26:24] is the bitwise OR of the fetched and old bits [26:24].
- R11: done is high for exactly one cycle, in the cycle after the 28th write, and busy is high from the first write through the done cycle.
- R12: A start pulse while an operation is in progress has no effect: the write count stays 28 and the final pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a push (taken only in idle) |
| lp_flag | input | 1 | Load the register block pointer from the fetched doubleword |
| gpr_flat | input | 512 | Sixteen 32-bit general registers, register n in bits [32n+31:32n] |
| old_psw | input | 64 | Current status doubleword |
| fetched_psw | input | 64 | Fetched new status doubleword |
| ptr_top_in | input | 17 | Initial stack top address |
| ptr_wc_in | input | 15 | Initial word count |
| ptr_ovf_in | input | 1 | Initial word count overflow flag |
| ptr_sc_in | input | 15 | Initial space count |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 17 | Memory write word address |
| mem_wdata | output | 32 | Memory write data |
| ptr_top | output | 17 | Working stack top address |
| ptr_wc | output | 15 | Working word count |
| ptr_ovf | output | 1 | Working overflow flag |
| ptr_sc | output | 15 | Working space count |
| new_psw | output | 64 | Resulting status doubleword |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The push is run with four patterns. The first is an ordinary case with the LP flag set and roomy counts. It shows that the register slot mapping, the status slots and the zeroed holes are distinct. The second starts the word count just below its limit and the space count below 28 with LP clear. It separates correct wrapping and overflow flagging from trapping or early exit, and it shows whether the old register block pointer is kept. The third enters with the overflow flag already set, which shows whether the flag is sticky. The fourth pulses start in the middle of a run, which shows whether the controller ignores a restart. Each run uses status patterns with different inhibit bits in old and fetched, so OR, copy and keep-old are all told apart.

// File: rtl/status_push_pkg.sv
package status_push_pkg;
    localparam int WORD_W      = 32;
    localparam int PSW_W       = 64;
    localparam int GPR_COUNT   = 16;
    localparam int FRAME_SLOTS = 28;
    // zero-based slot indices of the two status words (frame offsets +25, +26)
    localparam int PSW_HI_SLOT = 24;
    localparam int PSW_LO_SLOT = 25;
    // field positions inside a little-endian 64-bit status vector
    localparam int INH_LSB = 24;
    localparam int INH_W   = 3;
    localparam int RBP_LSB = 4;
    localparam int RBP_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PUSH   = 2'd1,
        ST_FINISH = 2'd2
    } push_state_t;
endpackage

// File: rtl/status_push_slot.sv
module status_push_slot
    import status_push_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0]            slot_idx,
    input  logic [GPR_COUNT*WORD_W-1:0] gpr_flat,
    input  logic [PSW_W-1:0]            psw,
    output logic [WORD_W-1:0]           wdata
);
    localparam int GPR_IDX_W = $clog2(GPR_COUNT);

    always_comb begin
        if (int'(slot_idx) < GPR_COUNT)
            wdata = gpr_flat[int'(slot_idx[GPR_IDX_W-1:0])*WORD_W +: WORD_W];
        else if (int'(slot_idx) == PSW_HI_SLOT)
            wdata = psw[PSW_W-1 -: WORD_W];
        else if (int'(slot_idx) == PSW_LO_SLOT)
            wdata = psw[WORD_W-1:0];
        else
            wdata = '0;
    end
endmodule

// File: rtl/status_push_ptr.sv
module status_push_ptr #(
    parameter int ADDR_W = 17,
    parameter int WC_W   = 15,
    parameter int SC_W   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] top_in,
    input  logic [WC_W-1:0]   wc_in,
    input  logic              ovf_in,
    input  logic [SC_W-1:0]   sc_in,
    output logic [ADDR_W-1:0] top_q,
    output logic [WC_W-1:0]   wc_q,
    output logic              ovf_q,
    output logic [SC_W-1:0]   sc_q
);
    logic [WC_W:0] wc_inc;
    assign wc_inc = {1'b0, wc_q} + {{WC_W{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
            wc_q  <= '0;
            ovf_q <= 1'b0;
            sc_q  <= '0;
        end else if (load) begin
            top_q <= top_in;
            wc_q  <= wc_in;
            ovf_q <= ovf_in;
            sc_q  <= sc_in;
        end else if (step) begin
            top_q <= top_q + ADDR_W'(1);
            wc_q  <= wc_inc[WC_W-1:0];
            ovf_q <= ovf_q | wc_inc[WC_W];
            sc_q  <= sc_q - SC_W'(1);
        end
    end

    p_wc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> wc_q == $past(wc_q) + WC_W'(1));
    p_sc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> sc_q == $past(sc_q) - SC_W'(1));
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !load |=> ovf_q);
endmodule

// File: rtl/status_push_merge.sv
module status_push_merge
    import status_push_pkg::*;
(
    input  logic             lp_flag,
    input  logic [PSW_W-1:0] fetched,
    input  logic [PSW_W-1:0] old,
    output logic [PSW_W-1:0] merged
);
    always_comb begin
        merged = fetched;
        merged[INH_LSB +: INH_W] = fetched[INH_LSB +: INH_W] | old[INH_LSB +: INH_W];
        if (!lp_flag)
            merged[RBP_LSB +: RBP_W] = old[RBP_LSB +: RBP_W];
    end
endmodule

// File: rtl/status_push_seq.sv
module status_push_seq
    import status_push_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int WC_W   = 15,
    parameter int SC_W   = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        lp_flag,
    input  logic [GPR_COUNT*WORD_W-1:0] gpr_flat,
    input  logic [PSW_W-1:0]            old_psw,
    input  logic [PSW_W-1:0]            fetched_psw,
    input  logic [ADDR_W-1:0]           ptr_top_in,
    input  logic [WC_W-1:0]             ptr_wc_in,
    input  logic                        ptr_ovf_in,
    input  logic [SC_W-1:0]             ptr_sc_in,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [WORD_W-1:0]           mem_wdata,
    output logic [ADDR_W-1:0]           ptr_top,
    output logic [WC_W-1:0]             ptr_wc,
    output logic                        ptr_ovf,
    output logic [SC_W-1:0]             ptr_sc,
    output logic [PSW_W-1:0]            new_psw,
    output logic                        busy,
    output logic                        done
);
    localparam int IDX_W = $clog2(FRAME_SLOTS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_SLOTS - 1);

    push_state_t                 state_q, state_d;
    logic [IDX_W-1:0]            idx_q;
    logic [GPR_COUNT*WORD_W-1:0] gpr_q;
    logic [PSW_W-1:0]            old_q, fetched_q, merged;
    logic                        lp_q;
    logic                        accept, step, last;
    logic [WORD_W-1:0]           slot_data;

    assign accept = (state_q == ST_IDLE) && start;
    assign last   = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PUSH;
            ST_PUSH:   if (last)  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        mem_we = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PUSH:   begin mem_we = 1'b1; busy = 1'b1; end
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    assign step = mem_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            gpr_q     <= '0;
            old_q     <= '0;
            fetched_q <= '0;
            lp_q      <= 1'b0;
            new_psw   <= '0;
        end else begin
            if (accept) begin
                idx_q     <= '0;
                gpr_q     <= gpr_flat;
                old_q     <= old_psw;
                fetched_q <= fetched_psw;
                lp_q      <= lp_flag;
            end else if (step) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            if (step && last)
                new_psw <= merged;
        end
    end

    status_push_ptr #(.ADDR_W(ADDR_W), .WC_W(WC_W), .SC_W(SC_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (step),
        .top_in (ptr_top_in),
        .wc_in  (ptr_wc_in),
        .ovf_in (ptr_ovf_in),
        .sc_in  (ptr_sc_in),
        .top_q  (ptr_top),
        .wc_q   (ptr_wc),
        .ovf_q  (ptr_ovf),
        .sc_q   (ptr_sc)
    );

    status_push_slot #(.IDX_W(IDX_W)) u_slot (
        .slot_idx (idx_q),
        .gpr_flat (gpr_q),
        .psw      (old_q),
        .wdata    (slot_data)
    );

    status_push_merge u_merge (
        .lp_flag (lp_q),
        .fetched (fetched_q),
        .old     (old_q),
        .merged  (merged)
    );

    assign mem_addr  = ptr_top + ADDR_W'(1);
    assign mem_wdata = slot_data;

    p_addr_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !last |=> mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1));
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && last |=> done);
    p_inhibit_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_psw[INH_LSB +: INH_W] & fetched_q[INH_LSB +: INH_W])
                 == fetched_q[INH_LSB +: INH_W]);
    p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(gpr_q));
endmodule

// File: tb/status_push_seq_bench.sv
module status_push_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         lp_flag = 1'b0;
    logic [511:0] gpr_flat = '0;
    logic [63:0]  old_psw = '0, fetched_psw = '0;
    logic [16:0]  ptr_top_in = '0;
    logic [14:0]  ptr_wc_in = '0;
    logic         ptr_ovf_in = 1'b0;
    logic [14:0]  ptr_sc_in = '0;
    logic         mem_we;
    logic [16:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic [16:0]  ptr_top;
    logic [14:0]  ptr_wc;
    logic         ptr_ovf;
    logic [14:0]  ptr_sc;
    logic [63:0]  new_psw;
    logic         busy, done;

    int total = 0;
    int bad = 0;
    logic [31:0] seen [28];
    int nwr;

    always #2 clk = ~clk;

    status_push_seq u_status_push_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lp_flag(lp_flag),
        .gpr_flat(gpr_flat), .old_psw(old_psw), .fetched_psw(fetched_psw),
        .ptr_top_in(ptr_top_in), .ptr_wc_in(ptr_wc_in), .ptr_ovf_in(ptr_ovf_in),
        .ptr_sc_in(ptr_sc_in), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .ptr_top(ptr_top), .ptr_wc(ptr_wc),
        .ptr_ovf(ptr_ovf), .ptr_sc(ptr_sc), .new_psw(new_psw),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_psw(input logic [63:0] f, input logic [63:0] o, input logic lp);
        logic [63:0] e;
        e = f;
        e[26:24] = f[26:24] | o[26:24];
        if (!lp) e[7:4] = o[7:4];
        return e;
    endfunction

    task automatic run_op(input logic [16:0] top, input logic [14:0] wc, input logic ovf,
                          input logic [14:0] sc, input logic lp, input logic [63:0] f,
                          input logic [63:0] o, input logic [31:0] seed, input bit restart);
        int ndone = 0;
        bit order_ok = 1;
        bit busy_ok = 1;
        logic [16:0] bad_addr = '0;
        logic [14:0] wc_exp;
        logic        ovf_exp;
        logic [15:0] wsum;
        for (int n = 0; n < 16; n++) gpr_flat[n*32 +: 32] = seed ^ (32'h0101_0101 * (n + 1));
        for (int s = 0; s < 28; s++) seen[s] = 32'hDEAD_BEEF;
        ptr_top_in = top; ptr_wc_in = wc; ptr_ovf_in = ovf; ptr_sc_in = sc;
        lp_flag = lp; fetched_psw = f; old_psw = o;
        nwr = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            start = (restart && (cyc == 5 || cyc == 20));
            if (!busy) busy_ok = 0;
            if (mem_we) begin
                if (nwr >= 28 || mem_addr != top + 17'(nwr + 1)) begin
                    order_ok = 0; bad_addr = mem_addr;
                end else seen[nwr] = mem_wdata;
                nwr++;
            end
            if (done) begin
                ndone++;
                chk(nwr == 28, "R11 done after 28th write", 64'(nwr), 64'd28);
                chk(ptr_top == top + 17'd28, "R6 final top", 64'(ptr_top), 64'(top + 17'd28));
                wsum = {1'b0, wc} + 16'd28;
                wc_exp = wsum[14:0];
                ovf_exp = ovf | wsum[15];
                chk(ptr_wc == wc_exp, "R6 final word count", 64'(ptr_wc), 64'(wc_exp));
                chk(ptr_sc == sc - 15'd28, "R6 final space count", 64'(ptr_sc), 64'(sc - 15'd28));
                chk(ptr_ovf == ovf_exp, "R7 overflow flag", 64'(ptr_ovf), 64'(ovf_exp));
                chk(new_psw == exp_psw(f, o, lp), "R8 R9 R10 new status", new_psw, exp_psw(f, o, lp));
                @(negedge clk);
                start = 1'b0;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(ndone == 1, "R11 one done pulse", 64'(ndone), 64'd1);
        chk(done == 1'b0 && busy == 1'b0, "R11 done one cycle then idle", {62'd0, done, busy}, 64'd0);
        chk(busy_ok, "R11 busy during run", 64'(busy_ok), 64'd1);
        chk(order_ok && nwr == 28, restart ? "R12 restart ignored, 28 writes" : "R2 28 ascending writes",
            {15'd0, bad_addr, 32'(nwr)}, 64'd28);
        for (int n = 0; n < 16; n++)
            chk(seen[n] == (seed ^ (32'h0101_0101 * (n + 1))), "R3 register slot",
                64'(seen[n]), 64'(seed ^ (32'h0101_0101 * (n + 1))));
        chk(seen[24] == o[63:32], "R4 status high slot", 64'(seen[24]), 64'(o[63:32]));
        chk(seen[25] == o[31:0], "R4 status low slot", 64'(seen[25]), 64'(o[31:0]));
        for (int s = 16; s < 28; s++)
            if (s != 24 && s != 25)
                chk(seen[s] == 32'd0, "R5 reserved slot zero", 64'(seen[s]), 64'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !mem_we, "R1 reset controls", {61'd0, busy, done, mem_we}, 64'd0);
        chk(new_psw == 64'd0, "R1 reset status", new_psw, 64'd0);
        chk(ptr_top == 0 && ptr_wc == 0 && ptr_sc == 0 && !ptr_ovf, "R1 reset pointer",
            {16'd0, ptr_top, ptr_wc, ptr_ovf, ptr_sc}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        // plain run, LP set
        run_op(17'h00100, 15'd5, 1'b0, 15'd100, 1'b1,
               64'h1234_5678_0200_00A0, 64'h8765_4321_0500_00F0, 32'hA5A5_0000, 1'b0);
        // word count near limit, space count runs out, LP clear
        run_op(17'h1FFF0, 15'd32760, 1'b0, 15'd10, 1'b0,
               64'hCAFE_F00D_0300_0050, 64'h0BAD_C0DE_0400_0030, 32'h5A5A_1111, 1'b0);
        // overflow flag already set
        run_op(17'h00040, 15'd7, 1'b1, 15'd500, 1'b0,
               64'h0000_0000_0000_00C0, 64'hFFFF_FFFF_0700_0010, 32'h0F0F_2222, 1'b0);
        // restart attempts during the run
        run_op(17'h00200, 15'd0, 1'b0, 15'd28, 1'b1,
               64'hFEDC_BA98_0100_0090, 64'h0123_4567_0600_0060, 32'h3C3C_3333, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule